// File: doc/BRIEF.md
# Input Change Detector with Interrupt Mask

This block watches a small group of general-purpose input pins that arrive from outside the clock domain. Each pin is brought into the local clock through a chain of synchronising flops. The block then reports two things in one status word: the present level of every pin, and a sticky flag for every pin that records whether its level has changed since software last looked.

Software reads the status word by pulsing a read strobe. The word it samples during the strobe cycle is the value it gets, and that same read clears every change flag. If a pin's change is detected in the very cycle of the read, the flag for that pin stays set, so no event is lost. A per-pin enable mask decides which change flags may raise one shared change interrupt bit. The mask is a plain input that is held in a register elsewhere.

Top module: `pin_change_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, with all pins held low, the status word is 8'h00 and the change interrupt is 0.
- R2: Status bits [3:0] show the synchronised level of pins [3:0] (1 = high). A level driven on a pin before clock edge k shows up in the status after edge k+1, and not after edge k.
- R3: Status bits [7:4] are the change flags of pins [3:0]. A rising or falling level on pin n, driven before edge k, sets bit 4+n after edge k+2, and not earlier.
- R4: A change flag is sticky. Once set, it stays set while no read happens, even when the pin goes back to its old level.
- R5: A read strobe that is high across a clock edge clears every change flag at that edge, unless R6 applies. The status word seen during the strobe cycle still holds the flags from before the clear.
- R6: If a new change on pin n is detected in the same cycle as a read, flag n is set after that edge. The read still clears the flags of the other pins.
- R7: The change interrupt is high exactly when some pin n has its change flag set and mask bit n = 1. A flag whose mask bit is 0 never raises it.
- R8: After a read that clears all change flags, the change interrupt is 0, whatever the mask.
- R9: The mask acts without delay. Setting a mask bit for a pin whose flag is already set raises the interrupt in the same cycle, and clearing the bit drops it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | 4 | Asynchronous general-purpose input pins |
| rd_stb_i | input | 1 | Status read strobe, one cycle per read |
| irq_mask_i | input | 4 | Per-pin interrupt enable; bit n enables pin n |
| status_o | output | 8 | {change flags[3:0], levels[3:0]} |
| chg_irq_o | output | 1 | Shared change interrupt bit |

## Verification
The bench builds the block with its default parameters: four pins and a two-flop synchroniser. With only four pins, all sixteen mask settings can be swept, and under each one every pin is toggled on its own. This covers every pairing of a flag with an enabled or disabled mask bit, as well as masks with several inputs enabled together. With the two-stage chain, the exact latency of the level bits and of the change flags can be checked edge by edge. It also lets the bench place a read exactly on the cycle in which a change is detected.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int unsigned PCM_PINS   = 4;
    localparam int unsigned PCM_SYNC   = 2;
    localparam int unsigned PCM_STAT_W = 2 * PCM_PINS;

    typedef struct packed {
        logic [PCM_PINS-1:0] chg;
        logic [PCM_PINS-1:0] lvl;
    } pcm_status_t;

    function automatic pcm_status_t pcm_pack(input logic [PCM_PINS-1:0] chg,
                                             input logic [PCM_PINS-1:0] lvl);
        pcm_status_t s;
        s.chg = chg;
        s.lvl = lvl;
        return s;
    endfunction

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[LAST];

endmodule

// File: rtl/pcm_chg_cell.sv
module pcm_chg_cell (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic rd_i,
    output logic det_o,
    output logic flag_o
);

    logic prev_q;
    logic flag_q;

    assign det_o = lvl_i ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            flag_q <= det_o | (flag_q & ~rd_i);
        end
    end

    assign flag_o = flag_q;

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !rd_i) |=> flag_o);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !det_o) |=> !flag_o);

    p_hit_on_read_r6: assert property (@(posedge clk) disable iff (rst)
        det_o |=> flag_o);

endmodule

// File: rtl/pcm_irq.sv
module pcm_irq #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] flags_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_o
);

    logic [WIDTH-1:0] hit;

    always_comb begin
        hit = flags_i & mask_i;
        irq_o = |hit;
    end

    always_comb begin
        if (flags_i == '0) begin
            p_no_irq_without_flag_r7: assert (!irq_o);
        end
        if (mask_i == '0) begin
            p_no_irq_without_mask_r7: assert (!irq_o);
        end
    end

endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
    import pcm_pkg::*;
#(
    parameter int unsigned NPINS = PCM_PINS,
    parameter int unsigned SYNC  = PCM_SYNC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPINS-1:0]     pins_i,
    input  logic                 rd_stb_i,
    input  logic [NPINS-1:0]     irq_mask_i,
    output logic [2*NPINS-1:0]   status_o,
    output logic                 chg_irq_o
);

    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] det;
    logic [NPINS-1:0] flags;

    pcm_sync #(.WIDTH(NPINS), .STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_i),
        .q_o (lvl)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_cell
        pcm_chg_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (lvl[n]),
            .rd_i   (rd_stb_i),
            .det_o  (det[n]),
            .flag_o (flags[n])
        );
    end

    pcm_irq #(.WIDTH(NPINS)) u_irq (
        .flags_i (flags),
        .mask_i  (irq_mask_i),
        .irq_o   (chg_irq_o)
    );

    assign status_o = {flags, lvl};

    p_irq_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && det == '0) |=> !chg_irq_o);

    p_flag_needs_change_r3: assert property (@(posedge clk) disable iff (rst)
        (flags == '0 && det == '0) |=> (flags == '0));

endmodule

// File: tb/pin_change_monitor_tb_top.sv
module pin_change_monitor_tb_top;

    localparam int unsigned CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] pins;
    logic       rd;
    logic [3:0] mask;
    logic [7:0] status;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_change_monitor dut_i (
        .clk        (clk),
        .rst        (rst),
        .pins_i     (pins),
        .rd_stb_i   (rd),
        .irq_mask_i (mask),
        .status_o   (status),
        .chg_irq_o  (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] seen);
        rd = 1'b1;
        seen = status;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; pins = '0; rd = 1'b0; mask = '0;
        cyc(3);
        chk("R1 status in reset", status, 8'h00);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        rst = 1'b0;
        cyc(1);
        chk("R1 status after reset", status, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_latency();
        logic [7:0] seen;
        pins = 4'b1010;
        cyc(1);
        chk("R2 level not yet after one edge", status, 8'h00);
        cyc(1);
        chk("R2 level after two edges / R3 no flag yet", status, 8'h0A);
        cyc(1);
        chk("R3 flags set after three edges", status, 8'hAA);
        chk("R7 masked-off flags give no irq", {7'b0, irq}, 8'h00);
        do_read(seen);
        chk("R5 value seen during read", seen, 8'hAA);
        chk("R5 flags cleared after read", status, 8'h0A);
    endtask

    task automatic t_sticky();
        logic [7:0] seen;
        pins[0] = 1'b1;
        cyc(3);
        pins[0] = 1'b0;
        cyc(6);
        chk("R4 flag sticky after pin returns", status, 8'h1A);
        do_read(seen);
        chk("R5 read clears sticky flag", status, 8'h0A);
        pins = 4'b0000;
        cyc(4);
        do_read(seen);
        chk("R3 falling edges flagged", seen, 8'hA0);
        chk("R5 cleared after falling-edge read", status, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] seen;
        pins[1] = 1'b1;
        cyc(4);
        chk("R3 setup flag on pin1", status, 8'h22);
        pins[2] = 1'b1;
        cyc(2);
        do_read(seen);
        chk("R6 flag kept on same-cycle change, others cleared", status, 8'h46);
        do_read(seen);
        chk("R5 later read clears it", status, 8'h06);
        pins = 4'b0000;
        cyc(4);
        do_read(seen);
    endtask

    task automatic t_mask_sweep();
        logic [7:0] seen;
        for (int m = 0; m < 16; m++) begin
            mask = m[3:0];
            for (int p = 0; p < 4; p++) begin
                pins[p] = ~pins[p];
                cyc(4);
                chk($sformatf("R7 irq mask=%0h pin=%0d", m, p), {7'b0, irq}, {7'b0, mask[p]});
                do_read(seen);
                chk($sformatf("R8 irq cleared mask=%0h pin=%0d", m, p), {7'b0, irq}, 8'h00);
            end
        end
    endtask

    task automatic t_live_mask();
        logic [7:0] seen;
        mask = 4'b0000;
        pins[3] = ~pins[3];
        cyc(4);
        chk("R9 no irq with bit clear", {7'b0, irq}, 8'h00);
        mask = 4'b1000;
        #1;
        chk("R9 irq rises at once with mask", {7'b0, irq}, 8'h01);
        mask = 4'b0100;
        #1;
        chk("R9 irq falls at once when unmasked", {7'b0, irq}, 8'h00);
        mask = 4'b1100;
        #1;
        chk("R7 two enabled inputs, one flagged", {7'b0, irq}, 8'h01);
        cyc(1);
        do_read(seen);
        chk("R8 irq clear after read", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_sticky();
        t_collision();
        t_mask_sweep();
        t_live_mask();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule